// File: doc/BRIEF.md
# Triple Edge-Triggered Storage Bit Bank with Shared Clock and Overrides

This block holds a small bank of independent single-bit storage elements, three by default. Each element has its own data input, its own clock input, its own set and its own clear. Every element drives a true output and a complement output. One shared clock input and a global set and global clear act on every element at once. An element's effective clock is the OR of its own clock and the shared clock. Data is taken in while that OR is low and is moved to the output when the OR rises.

The block is built for a synchronous fabric. Every storage clock, set and clear input is a level that the system clock `clk` samples; none of them is a real clock. A rising effective clock is found by comparing its sampled level with the level sampled in the previous cycle. The set and clear levels are applied on the next `clk` edge and take priority over a load. When a set and a clear are both active, both outputs of the element go high. When both are released with no load, the element settles to one. All outputs are registered. A synchronous active-high `rst` empties the bank and records the current clock levels, so an effective clock that is already high at reset does not count as a rising edge.

Top module: `triad_dff_bank`

## Requirements
- R1: While `rst` is high at a `clk` edge, every element goes to `q_o`=0 and `qn_o`=1. An effective clock that is high during reset does not load data after reset is released.
- R2: In every `clk` cycle in which an element's effective clock is sampled low, the element records `d_i`. A load uses the value recorded in the last such cycle.
- R3: At the first `clk` edge at which an element's effective clock is sampled high after being sampled low, `q_o` takes the recorded value and `qn_o` takes its inverse, provided no set or clear is active.
- R4: A rising `gclk_i` loads every element whose own clock is low.
- R5: A rising `bclk_i[i]` loads element i only. Bit i of every per-element bus belongs to element i.
- R6: With no set or clear active, an element keeps its value when its effective clock stays high, stays low or falls. It also keeps its value when `d_i` changes while the effective clock is high.
- R7: `bset_i[i]` alone gives `q_o[i]`=1 and `qn_o[i]`=0 at the next `clk` edge. `bclr_i[i]` alone gives `q_o[i]`=0 and `qn_o[i]`=1. Other elements are not affected.
- R8: `gset_i` sets every element and `gclr_i` clears every element, with the same one-cycle latency.
- R9: A set or clear that is active in the same cycle as a rising effective clock wins over the load. That rising edge is then used up.
- R10: When any set and any clear are active together on an element, both `q_o[i]` and `qn_o[i]` are 1. If they are released with no load, the element settles to `q_o`=1 and `qn_o`=0.
- R11: After the last set or clear is released, the element holds its value until the next rising edge of its effective clock, and then it loads.
- R12: In any cycle with no set or clear active, the next outputs are complements of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| d_i | input | NUM_BITS | Data input, one bit per element |
| bclk_i | input | NUM_BITS | Per-element storage clock level |
| gclk_i | input | 1 | Shared storage clock level for all elements |
| bset_i | input | NUM_BITS | Per-element set, active high |
| bclr_i | input | NUM_BITS | Per-element clear, active high |
| gset_i | input | 1 | Global set, active high |
| gclr_i | input | 1 | Global clear, active high |
| q_o | output | NUM_BITS | True outputs |
| qn_o | output | NUM_BITS | Complement outputs |

## Verification
The assertions assume that every storage clock, set, clear and data input is synchronous to `clk`. They also assume that each level is held for at least one full `clk` period, so that every rise and fall of an effective clock shows up as a difference between two consecutive samples. The stimulus changes inputs only on the falling edge of `clk`. It holds each vector for exactly one cycle and keeps `d_i` steady in the cycle before and the cycle of each rising storage clock, so the recorded value is unambiguous.

// File: rtl/triad_ff_pkg.sv
package triad_ff_pkg;
  // What one element does at the next clk edge.
  typedef enum logic [2:0] {
    ACT_HOLD = 3'd0,
    ACT_LOAD = 3'd1,
    ACT_SET  = 3'd2,
    ACT_CLR  = 3'd3,
    ACT_BOTH = 3'd4
  } ff_act_e;
endpackage

// File: rtl/triad_clk_qual.sv
module triad_clk_qual (
  input  logic clk,
  input  logic rst,
  input  logic bit_clk,
  input  logic glb_clk,
  input  logic d,
  output logic rise,
  output logic master
);
  logic eff;
  logic eff_prev;

  assign eff  = bit_clk | glb_clk;
  assign rise = eff & ~eff_prev;

  // The previous level is tracked in reset too, so a clock that is
  // already high at reset release does not count as a rising edge.
  always_ff @(posedge clk) begin
    eff_prev <= eff;
  end

  // The front stage is open only while the effective clock is low.
  always_ff @(posedge clk) begin
    if (rst) begin
      master <= 1'b0;
    end else if (!eff) begin
      master <= d;
    end
  end

  p_master_track_r2: assert property (@(posedge clk) disable iff (rst)
    (!(bit_clk | glb_clk)) |=> (master == $past(d)));

  p_master_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (bit_clk | glb_clk) |=> $stable(master));
endmodule

// File: rtl/triad_ovr_decode.sv
module triad_ovr_decode
  import triad_ff_pkg::*;
(
  input  logic    bit_set,
  input  logic    bit_clr,
  input  logic    glb_set,
  input  logic    glb_clr,
  input  logic    rise,
  output ff_act_e act
);
  logic set_any;
  logic clr_any;

  assign set_any = bit_set | glb_set;
  assign clr_any = bit_clr | glb_clr;

  // Priority: the set/clear levels first, then a rising clock, then hold.
  always_comb begin
    if (set_any && clr_any) begin
      act = ACT_BOTH;
    end else if (set_any) begin
      act = ACT_SET;
    end else if (clr_any) begin
      act = ACT_CLR;
    end else if (rise) begin
      act = ACT_LOAD;
    end else begin
      act = ACT_HOLD;
    end
  end
endmodule

// File: rtl/triad_bit_cell.sv
module triad_bit_cell
  import triad_ff_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic d,
  input  logic bit_clk,
  input  logic glb_clk,
  input  logic bit_set,
  input  logic bit_clr,
  input  logic glb_set,
  input  logic glb_clr,
  output logic q,
  output logic qn
);
  logic    rise;
  logic    master;
  ff_act_e act;

  triad_clk_qual u_qual (
    .clk     (clk),
    .rst     (rst),
    .bit_clk (bit_clk),
    .glb_clk (glb_clk),
    .d       (d),
    .rise    (rise),
    .master  (master)
  );

  triad_ovr_decode u_dec (
    .bit_set (bit_set),
    .bit_clr (bit_clr),
    .glb_set (glb_set),
    .glb_clr (glb_clr),
    .rise    (rise),
    .act     (act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      q  <= 1'b0;
      qn <= 1'b1;
    end else begin
      unique case (act)
        ACT_BOTH: begin q <= 1'b1;   qn <= 1'b1;    end
        ACT_SET:  begin q <= 1'b1;   qn <= 1'b0;    end
        ACT_CLR:  begin q <= 1'b0;   qn <= 1'b1;    end
        ACT_LOAD: begin q <= master; qn <= ~master; end
        default:  begin q <= q;      qn <= ~q;      end
      endcase
    end
  end

  logic s_on;
  logic c_on;
  assign s_on = bit_set | glb_set;
  assign c_on = bit_clr | glb_clr;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!q && qn));

  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (!s_on && !c_on && rise) |=> (q == $past(master)));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!s_on && !c_on && !rise) |=> $stable(q));

  p_set_r7: assert property (@(posedge clk) disable iff (rst)
    (s_on && !c_on) |=> (q && !qn));

  p_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (c_on && !s_on) |=> (!q && qn));

  p_both_high_r10: assert property (@(posedge clk) disable iff (rst)
    (s_on && c_on) |=> (q && qn));

  p_complement_r12: assert property (@(posedge clk) disable iff (rst)
    (!s_on && !c_on) |=> (qn == !q));
endmodule

// File: rtl/triad_dff_bank.sv
module triad_dff_bank #(
  parameter int NUM_BITS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_BITS-1:0] d_i,
  input  logic [NUM_BITS-1:0] bclk_i,
  input  logic                gclk_i,
  input  logic [NUM_BITS-1:0] bset_i,
  input  logic [NUM_BITS-1:0] bclr_i,
  input  logic                gset_i,
  input  logic                gclr_i,
  output logic [NUM_BITS-1:0] q_o,
  output logic [NUM_BITS-1:0] qn_o
);
  localparam int LAST_BIT = NUM_BITS - 1;

  for (genvar gi = 0; gi <= LAST_BIT; gi++) begin : g_cell
    triad_bit_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .d       (d_i[gi]),
      .bit_clk (bclk_i[gi]),
      .glb_clk (gclk_i),
      .bit_set (bset_i[gi]),
      .bit_clr (bclr_i[gi]),
      .glb_set (gset_i),
      .glb_clr (gclr_i),
      .q       (q_o[gi]),
      .qn      (qn_o[gi])
    );
  end

  p_glb_set_r8: assert property (@(posedge clk) disable iff (rst)
    (gset_i && !gclr_i && (bclr_i == '0)) |=> (q_o == '1 && qn_o == '0));

  p_glb_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (gclr_i && !gset_i && (bset_i == '0)) |=> (q_o == '0 && qn_o == '1));
endmodule

// File: tb/triad_dff_bank_tb.sv
module triad_dff_bank_tb;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] d_i, bclk_i, bset_i, bclr_i, q_o, qn_o;
  logic         gclk_i, gset_i, gclr_i;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  triad_dff_bank #(.NUM_BITS(N)) u_dut (
    .clk(clk), .rst(rst), .d_i(d_i), .bclk_i(bclk_i), .gclk_i(gclk_i),
    .bset_i(bset_i), .bclr_i(bclr_i), .gset_i(gset_i), .gclr_i(gclr_i),
    .q_o(q_o), .qn_o(qn_o)
  );

  // Bit fields: d(3) bclk(3) gclk bset(3) bclr(3) gset gclr | exp_q(3) exp_qn(3)
  localparam int NV = 24;
  localparam logic [20:0] VEC [NV] = '{
    21'b101_000_0_000_000_0_0_000_111, // R2 record, R6 hold
    21'b101_001_0_000_000_0_0_001_110, // R5 bit0 loads
    21'b010_001_0_000_000_0_0_001_110, // R6 d moves while high
    21'b010_000_0_000_000_0_0_001_110, // R6 falling edge
    21'b010_000_1_000_000_0_0_010_101, // R4 shared clock loads all
    21'b111_000_1_000_000_0_0_010_101, // R6 stays high
    21'b111_000_0_000_000_0_0_010_101, // R2 record 111
    21'b111_100_0_000_000_0_0_110_001, // R5 bit2 loads
    21'b111_100_1_000_000_0_0_111_000, // R4 bits 1,0 load, bit2 no edge
    21'b000_000_0_000_000_0_0_111_000, // R6 hold
    21'b000_000_0_000_010_0_0_101_010, // R7 clear bit1
    21'b000_000_0_000_000_0_0_101_010, // R11 hold after release
    21'b000_000_0_000_000_1_0_111_000, // R8 global set
    21'b000_000_0_000_000_0_1_000_111, // R8 global clear
    21'b000_000_1_001_000_0_0_001_110, // R9 set beats edge on bit0
    21'b000_000_1_000_000_0_0_001_110, // R11 edge used up
    21'b000_000_0_000_000_0_0_001_110, // R11 hold
    21'b000_000_1_000_000_0_0_000_111, // R11 next edge loads
    21'b000_000_0_100_100_0_0_100_111, // R10 set+clear bit2
    21'b000_000_0_000_000_0_0_100_011, // R10 release settles, R12
    21'b000_000_0_000_000_1_1_111_111, // R10 global set+clear
    21'b000_000_0_000_001_0_0_110_001, // R7 clear bit0, R12 others
    21'b011_000_0_000_000_0_0_110_001, // R2 record 011
    21'b011_011_0_000_000_0_0_111_000  // R3 bits 1,0 load
  };
  localparam string VTAG [NV] = '{
    "R6","R5","R6","R6","R4","R6","R2","R5","R4","R6","R7","R11",
    "R8","R8","R9","R11","R11","R11","R10","R10","R10","R7","R2","R3"
  };

  task automatic check(input logic [N-1:0] eq, input logic [N-1:0] eqn,
                       input string tag);
    n_chk++;
    if (q_o !== eq || qn_o !== eqn) begin
      n_fail++;
      $display("FAIL %s: actual q=%b qn=%b expected q=%b qn=%b",
               tag, q_o, qn_o, eq, eqn);
    end
  endtask

  task automatic drive(input logic [14:0] v);
    {d_i, bclk_i, gclk_i, bset_i, bclr_i, gset_i, gclr_i} = v;
  endtask

  initial begin
    rst = 1'b1;
    drive('0);
    repeat (2) @(negedge clk);
    check(3'b000, 3'b111, "R1");
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][20:6]);
      @(negedge clk);
      check(VEC[k][5:3], VEC[k][2:0], VTAG[k]);
    end

    // R1: reset with shared clock high, data all ones
    drive(15'b111_000_1_000_000_0_0);
    rst = 1'b1;
    @(negedge clk);
    check(3'b000, 3'b111, "R1");
    rst = 1'b0;
    @(negedge clk);
    check(3'b000, 3'b111, "R1");
    gclk_i = 1'b0;
    @(negedge clk);
    check(3'b000, 3'b111, "R6");
    gclk_i = 1'b1;
    @(negedge clk);
    check(3'b111, 3'b000, "R3");
    // R12: unused element with all controls low keeps its value
    gclk_i = 1'b0; d_i = 3'b000; bclk_i = 3'b011;
    @(negedge clk);
    check(3'b111, 3'b000, "R12");
    bclk_i = 3'b000;
    @(negedge clk);
    check(3'b111, 3'b000, "R6");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule